// File: doc/BRIEF.md
# Glitch-free grouped clock stop controller

This block sits between a clock synthesizer and the output pads. It gates a set of derived clocks in two groups. The processor group holds one processor clock, one interrupt-controller clock and a bank of memory clocks. The bus group holds the gated bus clocks. A free-running bus clock serves as the reference and is always passed straight through.

Each gated output has an enable bit from a serial register bank. Each group also has an active-low stop pin. An output runs only when its own bit and its group's stop pin both allow it. A mode input decides whether the stop pins are honoured at all.

Every run/stop request is first sampled on rising edges of the reference clock by a two-stage synchroniser. It then takes effect on the next falling edge of the clock being gated. As a result, an output never starts or ends inside a high phase. Stopped outputs rest low, and after reset every output stays low until its request has passed through the synchroniser once.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, every gated output is low. After release, outputs stay low for the first two reference rising edges and run from the third.
- R2: With mode_i at 0, cpu_stop_ni low forces cpu_clk_o, apic_clk_o and every sdram_clk_o bit low. Likewise, pci_stop_ni low forces every pci_clk_o bit low.
- R3: ref_clk_o follows ref_clk_i at all times, whatever the stop pins, the mode or the enable bits.
- R4: With mode_i at 1, both stop pins have no effect on any output.
- R5: A gated output runs only when its en_i bit is 1 and its group is allowed. The en_i bit order is: bit 0 for the processor clock, bit 1 for the interrupt-controller clock, bits 2 to N_SDRAM+1 for the memory clocks, and the remaining N_PCI bits for the bus clocks.
- R6: A request change made between reference edges is captured on the next reference rising edge and moved through a second stage on the following one. It then reaches the output at the next falling edge of that output's source clock. Outputs sampled in the high phase after the first and second reference edges keep the old state; the sample after the third edge shows the new state.
- R7: Every high pulse on a gated output lasts a full source high phase, and a stopped output rests low.
- R8: A low pulse on a stop pin that starts and ends between two reference rising edges has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Free-running reference bus clock |
| cpu_src_i | input | 1 | Processor clock source |
| apic_src_i | input | 1 | Interrupt-controller clock source |
| sdram_src_i | input | 1 | Memory clock source |
| pci_src_i | input | 1 | Bus clock source |
| mode_i | input | 1 | 1 disables the stop pins |
| cpu_stop_ni | input | 1 | Processor group stop, active low |
| pci_stop_ni | input | 1 | Bus group stop, active low |
| en_i | input | N_SDRAM+N_PCI+2 | Per-output enable bits |
| ref_clk_o | output | 1 | Free-running reference clock out |
| cpu_clk_o | output | 1 | Gated processor clock |
| apic_clk_o | output | 1 | Gated interrupt-controller clock |
| sdram_clk_o | output | N_SDRAM | Gated memory clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |

## Verification
The bench sweeps every mode and stop pin combination against walking-one, alternating, all-set and all-clear enable patterns. This exposes a group decoded onto the wrong outputs, or a mode that still honours the pins. It times a request change to the exact sample that must first show it, so a missing synchroniser stage or an extra one shows up as an output that switches one reference cycle early or late. A pulse-width monitor on every output flags a gate that changes during a high phase, which would leave a shortened pulse. A stop-pin glitch placed between reference edges catches a design that reacts to the pins asynchronously.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic {GRP_CPU = 1'b0, GRP_PCI = 1'b1} grp_e;

  typedef enum logic [1:0] {SRC_CPU, SRC_APIC, SRC_SDRAM, SRC_PCI} src_e;

  function automatic grp_e grp_of(input int idx, input int n_sdram);
    return (idx < n_sdram + 2) ? GRP_CPU : GRP_PCI;
  endfunction

  function automatic src_e src_of(input int idx, input int n_sdram);
    if (idx == 0) return SRC_CPU;
    if (idx == 1) return SRC_APIC;
    if (idx < n_sdram + 2) return SRC_SDRAM;
    return SRC_PCI;
  endfunction
endpackage

// File: rtl/clk_req_sync.sv
module clk_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic req_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], req_i};
  end

  assign req_o = stage_q[STAGES-1];

  // R6
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(req_i, STAGES));
  // R6
  sync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> !$past(req_i, STAGES));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic src_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clk_o
);
  logic gate_q;

  // falling-edge capture: gate only moves while the source is low
  always_ff @(negedge src_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= req_i;
  end

  assign clk_o = src_i & gate_q;

  // R6
  gate_rise_chk: assert property (@(negedge src_i) disable iff (!rst_ni)
    $rose(gate_q) |-> $past(req_i));
  // R7
  gate_fall_chk: assert property (@(negedge src_i) disable iff (!rst_ni)
    $fell(gate_q) |-> !$past(req_i));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int  N_SDRAM   = 13,
  parameter int  N_PCI     = 5,
  parameter int  SYNC_LEN  = 2,
  localparam int NOut      = N_SDRAM + N_PCI + 2
) (
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               cpu_src_i,
  input  logic               apic_src_i,
  input  logic               sdram_src_i,
  input  logic               pci_src_i,
  input  logic               mode_i,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic [NOut-1:0]    en_i,
  output logic               ref_clk_o,
  output logic               cpu_clk_o,
  output logic               apic_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o
);
  localparam int SdramLo = 2;
  localparam int PciLo   = N_SDRAM + 2;

  logic            cpu_allow, pci_allow;
  logic [NOut-1:0] req_raw, req_sync, src_vec, gated;

  assign cpu_allow = mode_i | cpu_stop_ni;
  assign pci_allow = mode_i | pci_stop_ni;

  for (genvar i = 0; i < NOut; i++) begin : g_out
    localparam grp_e GRP = grp_of(i, N_SDRAM);
    localparam src_e SRC = src_of(i, N_SDRAM);

    if (GRP == GRP_CPU) begin : g_cpu_grp
      assign req_raw[i] = en_i[i] & cpu_allow;
    end else begin : g_pci_grp
      assign req_raw[i] = en_i[i] & pci_allow;
    end

    if (SRC == SRC_CPU) begin : g_src_cpu
      assign src_vec[i] = cpu_src_i;
    end else if (SRC == SRC_APIC) begin : g_src_apic
      assign src_vec[i] = apic_src_i;
    end else if (SRC == SRC_SDRAM) begin : g_src_sdram
      assign src_vec[i] = sdram_src_i;
    end else begin : g_src_pci
      assign src_vec[i] = pci_src_i;
    end

    clk_req_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk_i  (ref_clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_raw[i]),
      .req_o  (req_sync[i])
    );

    clk_gate_cell u_gate (
      .src_i  (src_vec[i]),
      .rst_ni (rst_ni),
      .req_i  (req_sync[i]),
      .clk_o  (gated[i])
    );
  end

  assign ref_clk_o   = ref_clk_i;
  assign cpu_clk_o   = gated[0];
  assign apic_clk_o  = gated[1];
  assign sdram_clk_o = gated[PciLo-1:SdramLo];
  assign pci_clk_o   = gated[NOut-1:PciLo];

  // R4
  mode_ignore_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    mode_i |-> (req_raw == en_i));
  // R2
  cpu_stop_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!mode_i && !cpu_stop_ni) |-> (req_raw[PciLo-1:0] == '0));
  // R2
  pci_stop_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!mode_i && !pci_stop_ni) |-> (req_raw[NOut-1:PciLo] == '0));
endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
  localparam int NS = 13;
  localparam int NP = 5;
  localparam int NO = NS + NP + 2;

  logic rst_ni = 1'b0;
  logic fast = 1'b0;
  logic ref_clk = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, ps_n = 1'b1;
  logic [NO-1:0] en = '1;
  logic ref_o, cpu_o, apic_o;
  logic [NS-1:0] sdram_o;
  logic [NP-1:0] pci_o;
  logic [NO-1:0] bus;
  int vectors = 0, fails = 0, runts = 0;
  bit done = 0;
  realtime rise_t [NO];
  logic [NO-1:0] prev_bus = '0;

  always #2 fast = ~fast;
  always @(posedge fast) ref_clk <= ~ref_clk;  // 125 MHz reference

  clk_stop_ctrl #(.N_SDRAM(NS), .N_PCI(NP)) dut_i (
    .rst_ni(rst_ni), .ref_clk_i(ref_clk), .cpu_src_i(fast), .apic_src_i(ref_clk),
    .sdram_src_i(fast), .pci_src_i(ref_clk), .mode_i(mode), .cpu_stop_ni(cs_n),
    .pci_stop_ni(ps_n), .en_i(en), .ref_clk_o(ref_o), .cpu_clk_o(cpu_o),
    .apic_clk_o(apic_o), .sdram_clk_o(sdram_o), .pci_clk_o(pci_o));

  assign bus = {pci_o, sdram_o, apic_o, cpu_o};

  function automatic real half_of(input int i);
    return (i == 1 || i >= NS + 2) ? 4.0 : 2.0;
  endfunction

  // R7: every high pulse must last a whole source high phase
  always @(bus) begin
    for (int i = 0; i < NO; i++) begin
      if (bus[i] && !prev_bus[i]) rise_t[i] = $realtime;
      if (!bus[i] && prev_bus[i] && ($realtime - rise_t[i]) < half_of(i) - 0.01) runts++;
    end
    prev_bus = bus;
  end

  function automatic logic [NO-1:0] expect_bus(input logic [NO-1:0] e, input logic m,
                                               input logic c, input logic p);
    logic [NO-1:0] r;
    for (int i = 0; i < NO; i++)
      r[i] = e[i] & (m | ((i < NS + 2) ? c : p));
    return r;
  endfunction

  task automatic to_sample();
    @(posedge ref_clk);
    #1;
  endtask

  task automatic check_bus(input string rq, input logic [NO-1:0] exp);
    vectors++;
    if (bus !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", rq, bus, exp, $time);
    end
  endtask

  task automatic check_ref(input string rq);
    vectors++;
    if (ref_o !== 1'b1) begin
      fails++;
      $display("FAIL %s: ref_clk_o %b expected 1 at %0t", rq, ref_o, $time);
    end
  endtask

  function automatic logic [NO-1:0] pattern(input int p);
    if (p == 0) return '1;
    if (p == 1) return '0;
    if (p == 2) return {(NO+1)/2{2'b01}};
    return ({{(NO-1){1'b0}}, 1'b1} << (p - 3));
  endfunction

  initial begin
    logic [NO-1:0] old_exp;
    to_sample();
    // R1: reset holds everything low
    check_bus("R1", '0);
    to_sample();
    check_bus("R1", '0);
    rst_ni = 1'b1;
    to_sample(); check_bus("R1", '0);
    to_sample(); check_bus("R1", '0);
    to_sample(); check_bus("R1", '1);
    check_ref("R3");

    // R2 R4 R5 sweep: mode x stop pins x enable patterns
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < NO + 3; p++) begin
        {mode, cs_n, ps_n} = s[2:0];
        en = pattern(p);
        to_sample(); to_sample(); to_sample();
        if (mode) check_bus("R4", expect_bus(en, mode, cs_n, ps_n));
        else      check_bus("R2", expect_bus(en, mode, cs_n, ps_n));
        to_sample();
        check_bus("R5", expect_bus(en, mode, cs_n, ps_n));
        check_ref("R3");
      end
    end

    // R6: exact latency, stop then start
    mode = 0; cs_n = 1; ps_n = 1; en = '1;
    to_sample(); to_sample(); to_sample();
    en = {(NO+1)/2{2'b10}};
    old_exp = '1;
    to_sample(); check_bus("R6", old_exp);
    to_sample(); check_bus("R6", old_exp);
    to_sample(); check_bus("R6", en);
    en = '1;
    old_exp = {(NO+1)/2{2'b10}};
    to_sample(); check_bus("R6", old_exp);
    to_sample(); check_bus("R6", old_exp);
    to_sample(); check_bus("R6", '1);

    // R2 R6: processor-group pin latency
    cs_n = 0;
    to_sample(); check_bus("R6", '1);
    to_sample(); check_bus("R6", '1);
    to_sample(); check_bus("R2", expect_bus('1, 1'b0, 1'b0, 1'b1));
    cs_n = 1;
    to_sample(); to_sample(); to_sample();
    check_bus("R2", '1);

    // R8: stop glitches between reference edges
    cs_n = 0; ps_n = 0;
    #2;
    cs_n = 1; ps_n = 1;
    for (int k = 0; k < 4; k++) begin
      to_sample();
      check_bus("R8", '1);
    end

    // R7: single-cycle stop, then check pulse widths seen so far
    ps_n = 0; cs_n = 0;
    to_sample();
    ps_n = 1; cs_n = 1;
    for (int k = 0; k < 6; k++) to_sample();
    check_bus("R7", '1);
    vectors++;
    if (runts != 0) begin
      fails++;
      $display("FAIL R7: short pulses %0d expected 0", runts);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule